// File: doc/BRIEF.md
# Transmit Statistics Counter Bank with Threshold Interrupts

This block holds a set of transmit statistics counters for an Ethernet MAC together with one interrupt status register. Each counter has its own single-cycle event input from the transmit path, for example a good frame, an octet count step, a collision or a frame-size bucket hit. Every pulse advances its counter by one. A counter raises its own status bit when its value arrives at the midpoint of its range, where only the top bit is set, and again when it arrives at all-ones. The width of each counter is chosen at build time as either a narrow (default 16-bit) or a wide (default 32-bit) counter.

Software sees the bank through a simple read port with an address, four byte-lane enables and registered read data. Counter `i` sits at address `i` and the status register sits at address `NUM_CTR`. A status bit stays set until software reads the counter that raised it, using a read that includes byte lane 0. A global stop-rollover control makes counters stop at all-ones instead of wrapping. One interrupt output is the OR of all status bits.

Top module: `stat_irq_bank`

## Requirements
- R1: Each event pulse on `evt_i[i]` advances counter `i` by exactly one at the next clock edge. With no pulse, the counter keeps its value.
- R2: Counter `i` has width W. W is `WIDE_W` when `WIDE_MASK[i]` is 1 and `NARROW_W` otherwise, which by default is 32 bits (0x8000_0000 / 0xFFFF_FFFF) or 16 bits (0x8000 / 0xFFFF). Status bit `i` is set in the cycle after the counter reaches 2^(W-1) and in the cycle after it reaches 2^W-1.
- R3: Status bit `i` is set only by events on its own counter. Events on other counters never set it.
- R4: With `stop_roll_i` low, an event on a counter at all-ones wraps the counter to zero and does not set its status bit.
- R5: With `stop_roll_i` high, a counter at all-ones stays at all-ones on further events. Each such event sets its status bit again.
- R6: Status bit `i` is cleared only by a read with `rd_en_i`=1, `rd_addr_i`=`i` and `rd_be_i[0]`=1. A read of counter `i` with `rd_be_i[0]`=0 leaves the bit set.
- R7: The status register at address `NUM_CTR` holds status bit `i` at data bit `i`, and all higher bits read as zero. Reading it clears nothing. An address above `NUM_CTR` reads as zero.
- R8: `irq_o` is high exactly when at least one status bit is set.
- R9: If a threshold arrival and a clearing read of the same counter happen in the same cycle, the status bit ends up set.
- R10: After reset every counter, every status bit, `rd_data_o` and `irq_o` are zero.
- R11: `rd_data_o` is loaded at the clock edge that ends a cycle with `rd_en_i`=1. It carries the value the addressed register had in that cycle, with counters zero-extended to 32 bits. Byte lane b (bits 8b+7:8b) is zero when `rd_be_i[b]`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_CTR | One-cycle event pulse per counter |
| stop_roll_i | input | 1 | 1: counters stop at all-ones; 0: counters wrap to zero |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address: counter index, or NUM_CTR for the status register |
| rd_be_i | input | 4 | Byte-lane enables of the read |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | OR of all status bits |

## Verification
The hardest situations to reach from the ports are the counter thresholds. A default wide counter needs about two billion events before its midpoint, and far more for the all-ones and wrap cases. The bench therefore builds the bank with narrow widths of 8 and 12 bits, which keeps the same logic but puts every threshold within a few thousand pulses. It then drives long pulse trains into those boundaries: midpoint, all-ones, wrap, and the stopped state under stop-rollover. It also lines up a lane-0 read with the very pulse that reaches the midpoint, so the set-versus-clear race occurs in a single cycle.

// File: rtl/stat_irq_pkg.sv
// Package: shared constants and helpers for the statistics counter bank.
// Assumes a 32-bit register read bus split into four byte lanes.
package stat_irq_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;

    // Width of counter idx given the wide/narrow selection mask.
    function automatic int ctr_width(input logic wide_sel, input int narrow_w, input int wide_w);
        return wide_sel ? wide_w : narrow_w;
    endfunction
endpackage

// File: rtl/stat_ctr.sv
// Module: one statistics counter slice with its interrupt status bit.
// Counts single-cycle events, detects arrival at the midpoint and at
// all-ones, optionally stops at all-ones. Assumes 2 <= W <= DATA_W.
module stat_ctr
    import stat_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  evt_i,
    input  logic  stop_roll_i,
    input  logic  clr_i,
    output word_t cnt_o,
    output logic  flag_o
);
    localparam logic [W-1:0] MID  = W'(1) << (W - 1);
    localparam logic [W-1:0] FULL = '1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;
    logic         hold;
    logic         hit;
    logic         flag_q;

    // Next count value and threshold hit for the current event.
    always_comb begin
        hold    = stop_roll_i && (cnt_q == FULL);
        cnt_nxt = hold ? cnt_q : cnt_q + W'(1);
        hit     = evt_i && (hold || cnt_nxt == MID || cnt_nxt == FULL);
    end

    // Counter register: advances only on an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt_i) begin
            cnt_q <= cnt_nxt;
        end
    end

    // Status bit: a new hit takes priority over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign cnt_o  = DATA_W'(cnt_q);
    assign flag_o = flag_q;
endmodule

// File: rtl/stat_rd_port.sv
// Module: register read port of the counter bank.
// Selects a counter or the status word by address, masks byte lanes and
// registers the result; decodes clear-on-read strobes for lane-0 reads.
// Assumes NUM_CTR < 2**ADDR_W and NUM_CTR <= DATA_W.
module stat_rd_port
    import stat_irq_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int ADDR_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    input  logic [LANES-1:0]              rd_be_i,
    input  logic [NUM_CTR-1:0][DATA_W-1:0] ctr_val_i,
    input  logic [NUM_CTR-1:0]            flags_i,
    output logic [NUM_CTR-1:0]            clr_o,
    output word_t                         rd_data_o
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CTR);

    word_t sel_word;
    word_t lane_mask;
    word_t rd_q;

    // Clear strobe per counter: read of its address covering lane 0.
    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            clr_o[i] = rd_en_i && (rd_addr_i == ADDR_W'(i)) && rd_be_i[0];
        end
    end

    // Address decode: status word or one counter, zero elsewhere.
    always_comb begin
        sel_word = '0;
        if (rd_addr_i == STAT_ADDR) begin
            sel_word = DATA_W'(flags_i);
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_addr_i == ADDR_W'(i)) begin
                sel_word = ctr_val_i[i];
            end
        end
    end

    // Byte-lane mask built from the enables.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{rd_be_i[b]}};
    end

    // Read data register, loaded on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= sel_word & lane_mask;
        end
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/stat_irq_bank.sv
// Module: top of the transmit statistics counter bank.
// Instantiates one counter slice per event input (wide or narrow per
// WIDE_MASK) and the read port; drives the combined interrupt.
// Assumes WIDE_W and NARROW_W do not exceed 32 and NUM_CTR < 2**ADDR_W.
module stat_irq_bank
    import stat_irq_pkg::*;
#(
    parameter int                 NUM_CTR   = 4,
    parameter logic [NUM_CTR-1:0] WIDE_MASK = {(NUM_CTR/2){2'b01}},
    parameter int                 NARROW_W  = 16,
    parameter int                 WIDE_W    = 32,
    parameter int                 ADDR_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CTR-1:0]  evt_i,
    input  logic                stop_roll_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    input  logic [3:0]          rd_be_i,
    output logic [31:0]         rd_data_o,
    output logic                irq_o
);
    logic [NUM_CTR-1:0][DATA_W-1:0] ctr_val;
    logic [NUM_CTR-1:0]             flags;
    logic [NUM_CTR-1:0]             clr;

    // One counter slice per event input; width picked per slice.
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        localparam int CW = ctr_width(WIDE_MASK[i], NARROW_W, WIDE_W);
        stat_ctr #(.W(CW)) u_ctr (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt_i       (evt_i[i]),
            .stop_roll_i (stop_roll_i),
            .clr_i       (clr[i]),
            .cnt_o       (ctr_val[i]),
            .flag_o      (flags[i])
        );
    end

    // Register read port and clear-on-read decode.
    stat_rd_port #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_be_i   (rd_be_i),
        .ctr_val_i (ctr_val),
        .flags_i   (flags),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    // Combined interrupt.
    assign irq_o = |flags;
endmodule

// File: rtl/stat_irq_bank_chk.sv
// Module: assertion checker for stat_irq_bank, attached by bind.
// Observes ports plus the per-slice counts and status bits.
module stat_irq_bank_chk #(
    parameter int                 NUM_CTR   = 4,
    parameter logic [NUM_CTR-1:0] WIDE_MASK = {(NUM_CTR/2){2'b01}},
    parameter int                 NARROW_W  = 16,
    parameter int                 WIDE_W    = 32,
    parameter int                 ADDR_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CTR-1:0]        evt_i,
    input logic                      stop_roll_i,
    input logic                      rd_en_i,
    input logic [ADDR_W-1:0]         rd_addr_i,
    input logic [3:0]                rd_be_i,
    input logic [31:0]               rd_data_o,
    input logic                      irq_o,
    input logic [NUM_CTR-1:0][31:0]  ctr_val,
    input logic [NUM_CTR-1:0]        flags
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CTR);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        localparam int          CW   = WIDE_MASK[i] ? WIDE_W : NARROW_W;
        localparam logic [31:0] FULL = 32'((64'd1 << CW) - 64'd1);
        localparam logic [31:0] MID  = 32'(64'd1 << (CW - 1));

        // R1: an idle counter keeps its value.
        assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_i[i] |=> $stable(ctr_val[i]));

        // R1: an event below all-ones advances by one.
        assert_event_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] && ctr_val[i] != FULL |=> ctr_val[i] == $past(ctr_val[i]) + 32'd1);

        // R3: without its own event a clear status bit stays clear.
        assert_own_event_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[i] && !evt_i[i] |=> !flags[i]);

        // R4: wrap to zero when stop-rollover is off.
        assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] && !stop_roll_i && ctr_val[i] == FULL |=> ctr_val[i] == 32'd0);

        // R5: stop at all-ones and flag again.
        assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] && stop_roll_i && ctr_val[i] == FULL |=> ctr_val[i] == FULL && flags[i]);

        // R6: a set bit survives any cycle without a lane-0 read of its counter.
        assert_clear_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i] && !(rd_en_i && rd_addr_i == ADDR_W'(i) && rd_be_i[0]) |=> flags[i]);

        // R2, R9: arriving at the midpoint always leaves the bit set.
        assert_mid_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] && ctr_val[i] == MID - 32'd1 |=> flags[i]);
    end

    // R7: upper status bits read as zero.
    assert_status_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && rd_addr_i == STAT_ADDR |=> rd_data_o[31:NUM_CTR] == '0);

    // R8: the interrupt can only rise after some event.
    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && evt_i == '0 |=> !irq_o);
endmodule

bind stat_irq_bank stat_irq_bank_chk #(
    .NUM_CTR   (NUM_CTR),
    .WIDE_MASK (WIDE_MASK),
    .NARROW_W  (NARROW_W),
    .WIDE_W    (WIDE_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .stop_roll_i (stop_roll_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_be_i     (rd_be_i),
    .rd_data_o   (rd_data_o),
    .irq_o       (irq_o),
    .ctr_val     (ctr_val),
    .flags       (flags)
);

// File: tb/stat_irq_bank_tb.sv
`timescale 1ns/1ps
// Bench: counters 0 and 2 are 12-bit (mid 0x800, full 0xFFF); counters
// 1 and 3 are 8-bit (mid 0x80, full 0xFF). Status register at address 4.
module stat_irq_bank_tb;
    localparam int NUM_CTR = 4;
    localparam int ADDR_W  = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_CTR-1:0] evt = '0;
    logic               stop_roll = 1'b0;
    logic               rd_en = 1'b0;
    logic [ADDR_W-1:0]  rd_addr = '0;
    logic [3:0]         rd_be = '0;
    logic [31:0]        rd_data;
    logic               irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] d;

    always #2.5 clk = ~clk;

    stat_irq_bank #(
        .NUM_CTR(NUM_CTR), .WIDE_MASK(4'b0101),
        .NARROW_W(8), .WIDE_W(12), .ADDR_W(ADDR_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .stop_roll_i(stop_roll),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_be_i(rd_be),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    // Vector: {event pattern[23:20], pulse count[19:4], expected status[3:0]}
    localparam logic [23:0] VEC [5] = '{
        {4'b1111, 16'd127,  4'b0000},
        {4'b0010, 16'd1,    4'b0010},
        {4'b1000, 16'd1,    4'b1010},
        {4'b0101, 16'd1920, 4'b1010},
        {4'b0001, 16'd1,    4'b1011}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [NUM_CTR-1:0] e, input int n);
        @(negedge clk);
        evt = e;
        repeat (n) @(negedge clk);
        evt = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [3:0] be, output logic [31:0] q);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; rd_be = be;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R10 rd_data in reset", rd_data, 32'h0);
        chk("R10 irq in reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        rd(4'd4, 4'hF, d); chk("R10 status after reset", d, 32'h0);
        rd(4'd2, 4'hF, d); chk("R10 counter after reset", d, 32'h0);

        // Table walk: R1 counting, R2 thresholds, R3 per-counter bits
        for (int v = 0; v < 5; v++) begin
            pulse(VEC[v][23:20], int'(VEC[v][19:4]));
            rd(4'd4, 4'hF, d);
            chk($sformatf("R2 R3 status after vector %0d", v), d, {28'h0, VEC[v][3:0]});
        end
        chk("R8 irq with bits set", {31'h0, irq}, 32'h1);

        // R11 lane masking; R6 upper-lane read does not clear
        rd(4'd1, 4'b1110, d); chk("R11 lane0 masked", d, 32'h0);
        rd(4'd4, 4'hF, d);    chk("R6 upper-lane read keeps bit", d, 32'hB);
        rd(4'd1, 4'b0001, d); chk("R11 lane0 value", d, 32'h80);
        rd(4'd4, 4'hF, d);    chk("R6 lane0 read clears", d, 32'h9);
        rd(4'd4, 4'hF, d);    chk("R7 status read clears nothing", d, 32'h9);
        rd(4'd0, 4'hF, d);    chk("R1 wide count", d, 32'h800);
        rd(4'd2, 4'hF, d);    chk("R1 wide count below mid", d, 32'h7FF);
        rd(4'd7, 4'hF, d);    chk("R7 unmapped address", d, 32'h0);

        // R2 full value and R4 wrap
        pulse(4'b0010, 127);
        rd(4'd4, 4'hF, d);    chk("R2 narrow full sets", d, 32'hA);
        rd(4'd1, 4'hF, d);    chk("R2 narrow full value", d, 32'hFF);
        pulse(4'b0010, 1);
        rd(4'd4, 4'hF, d);    chk("R4 wrap sets nothing", d, 32'h8);
        rd(4'd1, 4'hF, d);    chk("R4 wrapped to zero", d, 32'h0);

        // R9 crossing and clearing read in one cycle
        pulse(4'b0010, 127);
        @(negedge clk);
        evt = 4'b0010; rd_en = 1'b1; rd_addr = 4'd1; rd_be = 4'b0001;
        @(negedge clk);
        evt = '0; rd_en = 1'b0;
        chk("R11 read sees pre-event value", rd_data, 32'd127);
        rd(4'd4, 4'hF, d);    chk("R9 crossing beats clear", d, 32'hA);

        // R5 stop-rollover
        rd(4'd3, 4'b0001, d); chk("R5 ctr3 at mid", d, 32'h80);
        stop_roll = 1'b1;
        pulse(4'b1000, 127);
        rd(4'd4, 4'hF, d);    chk("R5 full sets", d, 32'hA);
        rd(4'd3, 4'hF, d);    chk("R5 full value", d, 32'hFF);
        rd(4'd4, 4'hF, d);    chk("R5 cleared by read", d, 32'h2);
        pulse(4'b1000, 5);
        rd(4'd4, 4'hF, d);    chk("R5 held events set again", d, 32'hA);
        rd(4'd3, 4'hF, d);    chk("R5 held at all-ones", d, 32'hFF);
        stop_roll = 1'b0;

        // R2 wide full value
        pulse(4'b0100, 2048);
        rd(4'd4, 4'hF, d);    chk("R2 wide mid and full", d, 32'h6);
        rd(4'd2, 4'hF, d);    chk("R2 wide full value", d, 32'hFFF);
        rd(4'd1, 4'b0001, d); chk("R1 ctr1 after race", d, 32'h80);
        @(negedge clk);
        chk("R8 irq low when all clear", {31'h0, irq}, 32'h0);
        rd(4'd4, 4'hF, d);    chk("R7 status all clear", d, 32'h0);

        finish_run();
    end
endmodule